// File: doc/BRIEF.md
# Condition Code Evaluator

This block decides whether a conditionally executed instruction should run. It takes a 4-bit condition field and the four status flags: negative, zero, carry and overflow. It returns a single pass signal. It does not decode instructions, and it neither stores nor produces the flags. Fifteen condition codes are defined. They range from single-flag tests to compound unsigned and signed comparisons, and the last of them always passes. The sixteenth code is reserved. It always fails, and a separate output reports that it was used.

The evaluation is built as a vector of sixteen candidate results, one for each code, and the condition field picks one of them. A parameter selects one of two output variants. In the first, the result passes straight through with no latency. In the second, a single register stage with a valid qualifier sits at the output, so the result appears one clock after the operands.

Top module: `cond_pass_eval`

## Requirements
- R1: Code 0 passes when Z is 1. Code 1 passes when Z is 0.
- R2: Code 2 passes when C is 1. Code 3 passes when C is 0.
- R3: Code 4 passes when N is 1. Code 5 passes when N is 0.
- R4: Code 6 passes when V is 1. Code 7 passes when V is 0.
- R5: Code 8 (unsigned higher) passes only when C is 1 and Z is 0. Code 9 (lower or same) passes when C is 0 or Z is 1.
- R6: Code 10 (signed greater or equal) passes when N equals V. Code 11 (signed less) passes when N differs from V.
- R7: Code 12 (signed greater) passes when Z is 0 and N equals V. Code 13 (signed less or equal) passes when Z is 1 or N differs from V.
- R8: Code 14 passes for all sixteen flag combinations.
- R9: Code 15 always fails and drives out_reserved to 1. For codes 0 to 14, out_reserved is 0.
- R10: With REGISTERED=0 the outputs follow the inputs in the same cycle, and out_valid equals in_valid.
- R11: With REGISTERED=1, the out_pass and out_reserved values for an operand accepted with in_valid appear one clock later, together with out_valid=1. While reset is low, all outputs are 0.
- R12: With REGISTERED=1, a cycle with in_valid=0 drives out_valid to 0 on the next clock. In that case out_pass and out_reserved keep their earlier values, whatever the condition and flag inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered variant |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are valid this cycle |
| cond | input | 4 | Condition field, codes 0 to 15 |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| out_valid | output | 1 | The result is valid |
| out_pass | output | 1 | 1 when the instruction should execute |
| out_reserved | output | 1 | 1 when the reserved code was presented |

## Verification
A wrong compound term would give the wrong pass value for some flag patterns only. For example, a faulty signed test would show up only when N and V disagree, so the bench applies every code with all sixteen flag patterns. In the combinational variant, any error reaches out_pass within the same cycle. In the registered variant it appears exactly one clock later, alongside out_valid. A capture enable that was broken or inverted would show as a changed out_pass during a cycle where out_valid is 0.

// File: rtl/ccev_pkg.sv
package ccev_pkg;
  localparam int COND_W    = 4;
  localparam int NUM_CODES = 1 << COND_W;
  localparam int NUM_PAIRS = 7;

  typedef enum logic [COND_W-1:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_RSV = 4'd15
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // One positive term per pair of codes; the odd code of each pair is its inverse.
  function automatic logic [NUM_PAIRS-1:0] pair_terms(input flags_t f);
    logic same_sign;
    logic [NUM_PAIRS-1:0] t;
    same_sign = ~(f.n ^ f.v);
    t[0] = f.z;
    t[1] = f.c;
    t[2] = f.n;
    t[3] = f.v;
    t[4] = f.c & ~f.z;
    t[5] = same_sign;
    t[6] = ~f.z & same_sign;
    return t;
  endfunction
endpackage

// File: rtl/ccev_terms.sv
module ccev_terms
  import ccev_pkg::*;
(
  input  flags_t                 flags,
  output logic [NUM_PAIRS-1:0]   term
);
  assign term = pair_terms(flags);
endmodule

// File: rtl/ccev_table.sv
module ccev_table
  import ccev_pkg::*;
(
  input  logic [NUM_PAIRS-1:0] term,
  output logic [NUM_CODES-1:0] pass_vec
);
  for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
    if (i < 2*NUM_PAIRS) begin : g_pair
      if (i % 2 == 1) begin : g_odd
        assign pass_vec[i] = ~term[i/2];
      end else begin : g_even
        assign pass_vec[i] = term[i/2];
      end
    end else if (i == int'(CC_AL)) begin : g_always
      assign pass_vec[i] = 1'b1;
    end else begin : g_reserved
      assign pass_vec[i] = 1'b0;
    end
  end
endmodule

// File: rtl/ccev_select.sv
module ccev_select
  import ccev_pkg::*;
(
  input  logic [COND_W-1:0]    cond,
  input  logic [NUM_CODES-1:0] pass_vec,
  output logic                 pass,
  output logic                 rsv
);
  assign pass = pass_vec[cond];
  assign rsv  = (cond == CC_RSV);
endmodule

// File: rtl/ccev_stage.sv
module ccev_stage #(
  parameter bit REGISTERED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic d_pass,
  input  logic d_rsv,
  output logic q_valid,
  output logic q_pass,
  output logic q_rsv
);
  if (REGISTERED) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q_valid <= 1'b0;
        q_pass  <= 1'b0;
        q_rsv   <= 1'b0;
      end else begin
        q_valid <= in_valid;
        if (in_valid) begin
          q_pass <= d_pass;
          q_rsv  <= d_rsv;
        end
      end
    end
  end else begin : g_wire
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign q_valid = in_valid;
    assign q_pass  = d_pass;
    assign q_rsv   = d_rsv;
  end
endmodule

// File: rtl/cond_pass_eval.sv
module cond_pass_eval
  import ccev_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [COND_W-1:0] cond,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_v,
  output logic              out_valid,
  output logic              out_pass,
  output logic              out_reserved
);
  flags_t                 flags;
  logic [NUM_PAIRS-1:0]   term;
  logic [NUM_CODES-1:0]   pass_vec;
  logic                   eval_pass;
  logic                   eval_rsv;

  assign flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

  ccev_terms u_terms (.flags(flags), .term(term));
  ccev_table u_table (.term(term), .pass_vec(pass_vec));
  ccev_select u_select (.cond(cond), .pass_vec(pass_vec), .pass(eval_pass), .rsv(eval_rsv));

  ccev_stage #(.REGISTERED(REGISTERED)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .d_pass(eval_pass), .d_rsv(eval_rsv),
    .q_valid(out_valid), .q_pass(out_pass), .q_rsv(out_reserved)
  );
endmodule

// File: rtl/cond_pass_eval_chk.sv
module cond_pass_eval_chk #(
  parameter bit REGISTERED = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [3:0] cond,
  input logic       flag_n,
  input logic       flag_z,
  input logic       flag_c,
  input logic       flag_v,
  input logic       eval_pass,
  input logic       eval_rsv,
  input logic       out_valid,
  input logic       out_pass,
  input logic       out_reserved
);
  a_r1_eq: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'd0 |-> eval_pass == flag_z);
  a_r5_ls: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'd9 |-> eval_pass == (!flag_c || flag_z));
  a_r6_ge: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'd10 |-> eval_pass == (flag_n == flag_v));
  a_r7_gt: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'd12 |-> eval_pass == (!flag_z && flag_n == flag_v));
  a_r8_always: assert property (@(posedge clk) disable iff (!rst_n)
    cond == 4'd14 |-> eval_pass);
  a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    eval_rsv |-> !eval_pass && cond == 4'd15);

  if (REGISTERED) begin : g_reg_chk
    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid && out_pass == $past(eval_pass) && out_reserved == $past(eval_rsv));
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(out_pass) && $stable(out_reserved));
  end else begin : g_comb_chk
    a_r10_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid && out_pass == eval_pass && out_reserved == eval_rsv);
  end
endmodule

bind cond_pass_eval cond_pass_eval_chk #(.REGISTERED(REGISTERED)) u_chk (.*);

// File: tb/test_cond_pass_eval.sv
module test_cond_pass_eval;
  localparam time CLK_PERIOD = 10;
  localparam int  NDIR = 16;
  // {cond[3:0], n, z, c, v, expected pass}
  localparam logic [8:0] DIR_VEC [NDIR] = '{
    {4'd0,  4'b0100, 1'b1}, {4'd1,  4'b0100, 1'b0},
    {4'd2,  4'b0010, 1'b1}, {4'd3,  4'b1101, 1'b1},
    {4'd4,  4'b1000, 1'b1}, {4'd7,  4'b0001, 1'b0},
    {4'd8,  4'b0010, 1'b1}, {4'd8,  4'b0110, 1'b0},
    {4'd9,  4'b0000, 1'b1}, {4'd10, 4'b1001, 1'b1},
    {4'd11, 4'b1000, 1'b1}, {4'd12, 4'b0000, 1'b1},
    {4'd12, 4'b1101, 1'b0}, {4'd13, 4'b0001, 1'b1},
    {4'd14, 4'b0000, 1'b1}, {4'd15, 4'b1111, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [3:0] cond = 4'd0;
  logic fn = 1'b0, fz = 1'b0, fc = 1'b0, fv = 1'b0;
  logic r_valid, r_pass, r_rsv, c_valid, c_pass, c_rsv;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_pass_eval #(.REGISTERED(1'b1)) i_cond_pass_eval (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond),
    .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
    .out_valid(r_valid), .out_pass(r_pass), .out_reserved(r_rsv));

  cond_pass_eval #(.REGISTERED(1'b0)) i_cond_pass_eval_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond(cond),
    .flag_n(fn), .flag_z(fz), .flag_c(fc), .flag_v(fv),
    .out_valid(c_valid), .out_pass(c_pass), .out_reserved(c_rsv));

  // Reference written as explicit case analysis per code.
  function automatic logic ref_pass(input logic [3:0] cd, input logic n, z, c, v);
    case (cd)
      4'd0:  return z;          4'd1:  return !z;
      4'd2:  return c;          4'd3:  return !c;
      4'd4:  return n;          4'd5:  return !n;
      4'd6:  return v;          4'd7:  return !v;
      4'd8:  return c && !z;    4'd9:  return !c || z;
      4'd10: return n == v;     4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] cd);
    case (cd)
      4'd0, 4'd1:   return "R1";
      4'd2, 4'd3:   return "R2";
      4'd4, 4'd5:   return "R3";
      4'd6, 4'd7:   return "R4";
      4'd8, 4'd9:   return "R5";
      4'd10, 4'd11: return "R6";
      4'd12, 4'd13: return "R7";
      4'd14:        return "R8";
      default:      return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Drive away from the rising edge, check the comb variant before the edge
  // and the registered one just after it.
  task automatic apply(input logic [3:0] cd, input logic [3:0] nzcv, input logic exp);
    @(negedge clk);
    in_valid = 1'b1; cond = cd; {fn, fz, fc, fv} = nzcv;
    #1;
    check(req_of(cd), "comb pass", c_pass, exp);
    check("R9", "comb reserved", c_rsv, cd == 4'd15);
    check("R10", "comb valid", c_valid, 1'b1);
    @(posedge clk); #1;
    check(req_of(cd), "reg pass", r_pass, exp);
    check("R11", "reg reserved", r_rsv, cd == 4'd15);
    check("R11", "reg valid", r_valid, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    // R11: reset clears registered outputs even with in_valid high.
    in_valid = 1'b1; cond = 4'd14;
    repeat (3) @(posedge clk);
    #1;
    check("R11", "reset valid", r_valid, 1'b0);
    check("R11", "reset pass", r_pass, 1'b0);
    check("R11", "reset reserved", r_rsv, 1'b0);
    @(negedge clk); rst_n = 1'b1;

    // Directed table.
    for (int i = 0; i < NDIR; i++)
      apply(DIR_VEC[i][8:5], DIR_VEC[i][4:1], DIR_VEC[i][0]);

    // Full sweep: every code against every flag pattern.
    for (int cd = 0; cd < 16; cd++)
      for (int f = 0; f < 16; f++)
        apply(4'(cd), 4'(f), ref_pass(4'(cd), f[3], f[2], f[1], f[0]));

    // R12: hold when in_valid is low; R10: comb valid follows in_valid.
    apply(4'd15, 4'b0000, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; cond = 4'd14;
    #1;
    check("R10", "comb valid low", c_valid, 1'b0);
    check("R10", "comb pass same cycle", c_pass, 1'b1);
    @(posedge clk); #1;
    check("R12", "reg valid drops", r_valid, 1'b0);
    check("R12", "reg pass held", r_pass, 1'b0);
    check("R12", "reg reserved held", r_rsv, 1'b1);
    apply(4'd14, 4'b0000, 1'b1);
    @(negedge clk);
    in_valid = 1'b0; cond = 4'd0; {fn, fz, fc, fv} = 4'b0000;
    @(posedge clk); #1;
    check("R12", "reg pass held high", r_pass, 1'b1);
    check("R12", "reg reserved held low", r_rsv, 1'b0);
    check("R12", "reg valid low", r_valid, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule